// File: doc/BRIEF.md
# Digital Potentiometer Register Transfer Engine

This block keeps the state of four digital potentiometer channels. Each channel has one 8-bit wiper code, which sets the tap position on the resistor string, and four 8-bit stored-setting registers. The block carries out already-decoded commands on that state: direct writes and reads, copies in either direction between a stored setting and the wiper, and copies that act on all four channels at once. A separate step request moves one wiper by a single code, up or down. A step stops at the end of the code range instead of wrapping.

A serial front end decodes bus traffic into a one-cycle command strobe. It presents an opcode, a channel index, a stored-register index and a data byte. For fine tuning it can also issue step requests. The four wiper codes leave the block in parallel to drive the analog tap selectors. Reads return on a registered read-back byte.

Top module: `potreg_xfer_engine`

## Requirements
- R1: After synchronous reset, every wiper code and every stored-setting register holds 8'h80, and `rd_data` holds 8'h00.
- R2: A command applies on the first rising edge at which `cmd_valid` is high, and uses the values the registers held before that edge. Opcode 3'd2 writes `cmd_data` into the wiper of channel `cmd_pot`. Opcode 3'd3 writes `cmd_data` into stored register `cmd_reg` of channel `cmd_pot`. Opcode 3'd0 returns the wiper of `cmd_pot` on `rd_data`. Opcode 3'd1 returns stored register `cmd_reg` of `cmd_pot` on `rd_data`.
- R3: Opcode 3'd4 copies stored register `cmd_reg` of channel `cmd_pot` into that channel's wiper. The other wipers do not change.
- R4: Opcode 3'd5 copies the wiper of channel `cmd_pot` into its stored register `cmd_reg`. The other stored registers do not change.
- R5: Opcode 3'd6 loads every channel's wiper from that channel's own stored register `cmd_reg`, all in the same edge.
- R6: Opcode 3'd7 saves every channel's wiper into that channel's own stored register `cmd_reg`, all in the same edge.
- R7: A step request (`step_valid` high with `step_up` = 1) raises the wiper of channel `step_pot` by one code, toward the high terminal, on the next edge.
- R8: A step request with `step_up` = 0 lowers the wiper of channel `step_pot` by one code, toward the low terminal.
- R9: Stepping saturates. A wiper at 8'hFF stays at 8'hFF when stepped up, and a wiper at 8'h00 stays at 8'h00 when stepped down.
- R10: A step request in a cycle where `cmd_valid` is high is ignored, even when the command does not touch that wiper.
- R11: `rd_data` changes only on opcodes 3'd0 and 3'd1. Wipers change only on a step or on opcodes 3'd2, 3'd4 and 3'd6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Command opcode (see R2 to R6) |
| cmd_pot | input | 2 | Channel index for single-channel commands |
| cmd_reg | input | 2 | Stored-register index |
| cmd_data | input | 8 | Write data for opcodes 3'd2 and 3'd3 |
| step_valid | input | 1 | One-cycle step request |
| step_pot | input | 2 | Channel to step |
| step_up | input | 1 | Step direction, 1 toward the high terminal |
| wiper_code | output | 32 | Wiper codes, channel n at bits [8n+7:8n] |
| rd_data | output | 8 | Registered read-back byte |

## Verification
A wiper that is wrong is visible directly on `wiper_code` on the first falling edge after the faulty update. A stored register that is wrong stays hidden until it is read with opcode 3'd1, or until it is copied into a wiper with opcode 3'd4 or 3'd6. So the bench follows every copy into a stored register with a read-back on the following cycle. A wrong index or a wrong direction in the global copies shows as one channel that disagrees while its neighbours match. For that reason each global test first gives every channel a distinct value.

// File: rtl/potreg_pkg.sv
package potreg_pkg;

    localparam int POT_CNT   = 4;
    localparam int CODE_W    = 8;
    localparam int DREG_CNT  = 4;
    localparam int POT_IDX_W = $clog2(POT_CNT);
    localparam int REG_IDX_W = $clog2(DREG_CNT);
    localparam int OPC_W     = 3;

    localparam logic [CODE_W-1:0] CODE_MID = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] CODE_MIN = '0;

    typedef enum logic [OPC_W-1:0] {
        OPC_RD_WIPER  = 3'd0,
        OPC_RD_DREG   = 3'd1,
        OPC_WR_WIPER  = 3'd2,
        OPC_WR_DREG   = 3'd3,
        OPC_LOAD_ONE  = 3'd4,
        OPC_SAVE_ONE  = 3'd5,
        OPC_LOAD_ALL  = 3'd6,
        OPC_SAVE_ALL  = 3'd7
    } opc_e;

    typedef enum logic {
        WSRC_BUS  = 1'b0,
        WSRC_DREG = 1'b1
    } wsrc_e;

    typedef enum logic {
        DSRC_BUS   = 1'b0,
        DSRC_WIPER = 1'b1
    } dsrc_e;

    typedef struct packed {
        logic                 wiper_load;
        wsrc_e                wiper_src;
        logic                 dreg_we;
        dsrc_e                dreg_src;
        logic [REG_IDX_W-1:0] reg_idx;
        logic                 step_en;
        logic                 step_up;
    } chan_ctrl_t;

    function automatic logic opc_is_global(input opc_e op);
        return (op == OPC_LOAD_ALL) || (op == OPC_SAVE_ALL);
    endfunction

    function automatic logic [CODE_W-1:0] sat_step(input logic [CODE_W-1:0] code,
                                                   input logic              up);
        logic [CODE_W-1:0] res;
        if (up) res = (code == CODE_MAX) ? code : code + CODE_W'(1);
        else    res = (code == CODE_MIN) ? code : code - CODE_W'(1);
        return res;
    endfunction

endpackage

// File: rtl/potreg_cmd_decode.sv
module potreg_cmd_decode
    import potreg_pkg::*;
#(
    parameter int N_POTS = POT_CNT
) (
    input  logic                 cmd_valid,
    input  opc_e                 cmd_op,
    input  logic [POT_IDX_W-1:0] cmd_pot,
    input  logic [REG_IDX_W-1:0] cmd_reg,
    input  logic                 step_valid,
    input  logic [POT_IDX_W-1:0] step_pot,
    input  logic                 step_up,
    output chan_ctrl_t           ctrl_o [N_POTS]
);

    for (genvar p = 0; p < N_POTS; p++) begin : g_pot
        logic       sel;
        chan_ctrl_t c;

        assign sel = cmd_valid &&
                     (opc_is_global(cmd_op) || (cmd_pot == POT_IDX_W'(p)));

        always_comb begin
            c            = '0;
            c.wiper_src  = WSRC_BUS;
            c.dreg_src   = DSRC_BUS;
            c.reg_idx    = cmd_reg;
            c.step_up    = step_up;
            if (sel) begin
                unique case (cmd_op)
                    OPC_WR_WIPER: begin
                        c.wiper_load = 1'b1;
                        c.wiper_src  = WSRC_BUS;
                    end
                    OPC_WR_DREG: begin
                        c.dreg_we  = 1'b1;
                        c.dreg_src = DSRC_BUS;
                    end
                    OPC_LOAD_ONE, OPC_LOAD_ALL: begin
                        c.wiper_load = 1'b1;
                        c.wiper_src  = WSRC_DREG;
                    end
                    OPC_SAVE_ONE, OPC_SAVE_ALL: begin
                        c.dreg_we  = 1'b1;
                        c.dreg_src = DSRC_WIPER;
                    end
                    default: ;
                endcase
            end
            c.step_en = !cmd_valid && step_valid && (step_pot == POT_IDX_W'(p));
        end

        assign ctrl_o[p] = c;
    end

endmodule

// File: rtl/potreg_channel.sv
module potreg_channel
    import potreg_pkg::*;
#(
    parameter int W       = CODE_W,
    parameter int N_DREGS = DREG_CNT
) (
    input  logic                      clk,
    input  logic                      rst,
    input  chan_ctrl_t                ctrl,
    input  logic [W-1:0]              bus_data,
    output logic [W-1:0]              wiper_o,
    output logic [N_DREGS-1:0][W-1:0] dreg_o
);

    logic [W-1:0]              wiper_q;
    logic [W-1:0]              wiper_d;
    logic [N_DREGS-1:0][W-1:0] dreg_q;
    logic [W-1:0]              dreg_wdata;
    logic [W-1:0]              dreg_sel;

    assign dreg_sel   = dreg_q[ctrl.reg_idx];
    assign dreg_wdata = (ctrl.dreg_src == DSRC_WIPER) ? wiper_q : bus_data;

    always_comb begin
        wiper_d = wiper_q;
        if (ctrl.wiper_load) begin
            wiper_d = (ctrl.wiper_src == WSRC_DREG) ? dreg_sel : bus_data;
        end else if (ctrl.step_en) begin
            wiper_d = sat_step(wiper_q, ctrl.step_up);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) wiper_q <= CODE_MID;
        else     wiper_q <= wiper_d;
    end

    for (genvar r = 0; r < N_DREGS; r++) begin : g_dreg
        always_ff @(posedge clk) begin
            if (rst) begin
                dreg_q[r] <= CODE_MID;
            end else if (ctrl.dreg_we && (ctrl.reg_idx == REG_IDX_W'(r))) begin
                dreg_q[r] <= dreg_wdata;
            end
        end
    end

    assign wiper_o = wiper_q;
    assign dreg_o  = dreg_q;

endmodule

// File: rtl/potreg_readback.sv
module potreg_readback
    import potreg_pkg::*;
#(
    parameter int N_POTS  = POT_CNT,
    parameter int N_DREGS = DREG_CNT,
    parameter int W       = CODE_W
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  cmd_valid,
    input  opc_e                                  cmd_op,
    input  logic [POT_IDX_W-1:0]                  cmd_pot,
    input  logic [REG_IDX_W-1:0]                  cmd_reg,
    input  logic [N_POTS-1:0][W-1:0]              wipers,
    input  logic [N_POTS-1:0][N_DREGS-1:0][W-1:0] dregs,
    output logic [W-1:0]                          rd_data_o
);

    logic [W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (cmd_valid) begin
            if (cmd_op == OPC_RD_WIPER)     rd_q <= wipers[cmd_pot];
            else if (cmd_op == OPC_RD_DREG) rd_q <= dregs[cmd_pot][cmd_reg];
        end
    end

    assign rd_data_o = rd_q;

endmodule

// File: rtl/potreg_xfer_engine.sv
module potreg_xfer_engine
    import potreg_pkg::*;
#(
    parameter int N_POTS  = POT_CNT,
    parameter int N_DREGS = DREG_CNT,
    parameter int W       = CODE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  logic [OPC_W-1:0]     cmd_op,
    input  logic [POT_IDX_W-1:0] cmd_pot,
    input  logic [REG_IDX_W-1:0] cmd_reg,
    input  logic [W-1:0]         cmd_data,
    input  logic                 step_valid,
    input  logic [POT_IDX_W-1:0] step_pot,
    input  logic                 step_up,
    output logic [N_POTS*W-1:0]  wiper_code,
    output logic [W-1:0]         rd_data
);

    opc_e                                  op;
    chan_ctrl_t                            ctrl [N_POTS];
    logic [N_POTS-1:0][W-1:0]              wipers;
    logic [N_POTS-1:0][N_DREGS-1:0][W-1:0] dregs;

    assign op = opc_e'(cmd_op);

    potreg_cmd_decode #(.N_POTS(N_POTS)) u_decode (
        .cmd_valid  (cmd_valid),
        .cmd_op     (op),
        .cmd_pot    (cmd_pot),
        .cmd_reg    (cmd_reg),
        .step_valid (step_valid),
        .step_pot   (step_pot),
        .step_up    (step_up),
        .ctrl_o     (ctrl)
    );

    for (genvar p = 0; p < N_POTS; p++) begin : g_chan
        potreg_channel #(.W(W), .N_DREGS(N_DREGS)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .ctrl     (ctrl[p]),
            .bus_data (cmd_data),
            .wiper_o  (wipers[p]),
            .dreg_o   (dregs[p])
        );
    end

    potreg_readback #(.N_POTS(N_POTS), .N_DREGS(N_DREGS), .W(W)) u_readback (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (op),
        .cmd_pot   (cmd_pot),
        .cmd_reg   (cmd_reg),
        .wipers    (wipers),
        .dregs     (dregs),
        .rd_data_o (rd_data)
    );

    assign wiper_code = wipers;

endmodule

// File: rtl/potreg_xfer_engine_chk.sv
module potreg_xfer_engine_chk
    import potreg_pkg::*;
#(
    parameter int N_POTS = POT_CNT,
    parameter int W      = CODE_W
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cmd_valid,
    input logic [OPC_W-1:0]     cmd_op,
    input logic [POT_IDX_W-1:0] cmd_pot,
    input logic [W-1:0]         cmd_data,
    input logic                 step_valid,
    input logic [POT_IDX_W-1:0] step_pot,
    input logic                 step_up,
    input logic [N_POTS*W-1:0]  wiper_code,
    input logic [W-1:0]         rd_data
);

    function automatic logic [W-1:0] pick(input logic [N_POTS*W-1:0] v,
                                          input logic [POT_IDX_W-1:0] i);
        return v[int'(i)*W +: W];
    endfunction

    logic step_alone;
    assign step_alone = !cmd_valid && step_valid;

    // R2
    wr_wiper_lands_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_op == 3'd2 |=> pick(wiper_code, $past(cmd_pot)) == $past(cmd_data));

    // R7
    step_up_inc_chk: assert property (@(posedge clk) disable iff (rst)
        step_alone && step_up && pick(wiper_code, step_pot) != {W{1'b1}}
        |=> pick(wiper_code, $past(step_pot)) == $past(pick(wiper_code, step_pot)) + W'(1));

    // R8
    step_dn_dec_chk: assert property (@(posedge clk) disable iff (rst)
        step_alone && !step_up && pick(wiper_code, step_pot) != '0
        |=> pick(wiper_code, $past(step_pot)) == $past(pick(wiper_code, step_pot)) - W'(1));

    // R9
    sat_top_chk: assert property (@(posedge clk) disable iff (rst)
        step_alone && step_up && pick(wiper_code, step_pot) == {W{1'b1}}
        |=> pick(wiper_code, $past(step_pot)) == {W{1'b1}});

    // R9
    sat_bottom_chk: assert property (@(posedge clk) disable iff (rst)
        step_alone && !step_up && pick(wiper_code, step_pot) == '0
        |=> pick(wiper_code, $past(step_pot)) == '0);

    // R10
    read_blocks_step_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && (cmd_op == 3'd0 || cmd_op == 3'd1) |=> $stable(wiper_code));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid && !step_valid |=> $stable(wiper_code) && $stable(rd_data));

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_op[2:1] != 2'b00 |=> $stable(rd_data));

endmodule

bind potreg_xfer_engine potreg_xfer_engine_chk #(.N_POTS(N_POTS), .W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_pot    (cmd_pot),
    .cmd_data   (cmd_data),
    .step_valid (step_valid),
    .step_pot   (step_pot),
    .step_up    (step_up),
    .wiper_code (wiper_code),
    .rd_data    (rd_data)
);

// File: tb/potreg_xfer_engine_tb.sv
module potreg_xfer_engine_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [1:0]  cmd_pot = '0;
    logic [1:0]  cmd_reg = '0;
    logic [7:0]  cmd_data = '0;
    logic        step_valid = 1'b0;
    logic [1:0]  step_pot = '0;
    logic        step_up = 1'b0;
    logic [31:0] wiper_code;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] mw [4];
    logic [7:0] md [4][4];
    logic [7:0] mrd;

    always #5 clk = ~clk;

    potreg_xfer_engine u_dut (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_pot    (cmd_pot),
        .cmd_reg    (cmd_reg),
        .cmd_data   (cmd_data),
        .step_valid (step_valid),
        .step_pot   (step_pot),
        .step_up    (step_up),
        .wiper_code (wiper_code),
        .rd_data    (rd_data)
    );

    task automatic check8(input string req, input string what,
                          input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic check_wipers(input string req);
        for (int p = 0; p < 4; p++)
            check8(req, $sformatf("wiper %0d", p), wiper_code[p*8 +: 8], mw[p]);
    endtask

    // reference model of one command, using pre-edge values
    task automatic model_cmd(input logic [2:0] op, input logic [1:0] pot,
                             input logic [1:0] rg, input logic [7:0] data);
        logic [7:0] ow [4];
        for (int p = 0; p < 4; p++) ow[p] = mw[p];
        case (op)
            3'd0: mrd = mw[pot];
            3'd1: mrd = md[pot][rg];
            3'd2: mw[pot] = data;
            3'd3: md[pot][rg] = data;
            3'd4: mw[pot] = md[pot][rg];
            3'd5: md[pot][rg] = ow[pot];
            3'd6: for (int p = 0; p < 4; p++) mw[p] = md[p][rg];
            default: for (int p = 0; p < 4; p++) md[p][rg] = ow[p];
        endcase
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [1:0] pot,
                          input logic [1:0] rg, input logic [7:0] data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_pot = pot; cmd_reg = rg; cmd_data = data;
        model_cmd(op, pot, rg, data);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_step(input logic [1:0] pot, input logic up);
        @(negedge clk);
        step_valid = 1'b1; step_pot = pot; step_up = up;
        if (up  && mw[pot] != 8'hFF) mw[pot] = mw[pot] + 8'd1;
        if (!up && mw[pot] != 8'h00) mw[pot] = mw[pot] - 8'd1;
        @(negedge clk);
        step_valid = 1'b0;
    endtask

    task automatic read_dreg(input string req, input logic [1:0] pot, input logic [1:0] rg);
        do_cmd(3'd1, pot, rg, 8'h00);
        check8(req, $sformatf("stored %0d/%0d", pot, rg), rd_data, mrd);
    endtask

    task automatic t_reset;
        check_wipers("R1");
        check8("R1", "rd_data after reset", rd_data, 8'h00);
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < 4; r++) read_dreg("R1", p[1:0], r[1:0]);
    endtask

    task automatic t_direct;
        do_cmd(3'd2, 2'd1, 2'd0, 8'h3C);
        check_wipers("R2");
        do_cmd(3'd3, 2'd2, 2'd3, 8'hA5);
        check_wipers("R2");
        read_dreg("R2", 2'd2, 2'd3);
        do_cmd(3'd0, 2'd1, 2'd0, 8'h00);
        check8("R2", "read wiper 1", rd_data, 8'h3C);
    endtask

    task automatic t_load_one;
        do_cmd(3'd3, 2'd3, 2'd1, 8'h17);
        do_cmd(3'd4, 2'd3, 2'd1, 8'h00);
        check_wipers("R3");
        check8("R3", "wiper 3 loaded", wiper_code[31:24], 8'h17);
    endtask

    task automatic t_save_one;
        do_cmd(3'd2, 2'd0, 2'd0, 8'hC4);
        do_cmd(3'd5, 2'd0, 2'd2, 8'h00);
        check_wipers("R4");
        read_dreg("R4", 2'd0, 2'd2);
        read_dreg("R4", 2'd1, 2'd2);
    endtask

    task automatic t_load_all;
        for (int p = 0; p < 4; p++) do_cmd(3'd3, p[1:0], 2'd2, 8'h21 + 8'(p * 16));
        do_cmd(3'd6, 2'd0, 2'd2, 8'h00);
        check_wipers("R5");
    endtask

    task automatic t_save_all;
        for (int p = 0; p < 4; p++) do_cmd(3'd2, p[1:0], 2'd0, 8'h90 - 8'(p * 5));
        do_cmd(3'd7, 2'd2, 2'd1, 8'h00);
        for (int p = 0; p < 4; p++) read_dreg("R6", p[1:0], 2'd1);
        read_dreg("R6", 2'd3, 2'd0);
    endtask

    task automatic t_step;
        do_cmd(3'd2, 2'd2, 2'd0, 8'h40);
        do_step(2'd2, 1'b1);
        do_step(2'd2, 1'b1);
        check_wipers("R7");
        check8("R7", "wiper 2 up", wiper_code[23:16], 8'h42);
        do_step(2'd1, 1'b0);
        check_wipers("R8");
    endtask

    task automatic t_saturate;
        do_cmd(3'd2, 2'd3, 2'd0, 8'hFE);
        do_step(2'd3, 1'b1);
        do_step(2'd3, 1'b1);
        check8("R9", "wiper 3 top", wiper_code[31:24], 8'hFF);
        do_cmd(3'd2, 2'd0, 2'd0, 8'h01);
        do_step(2'd0, 1'b0);
        do_step(2'd0, 1'b0);
        check8("R9", "wiper 0 bottom", wiper_code[7:0], 8'h00);
        check_wipers("R9");
    endtask

    task automatic t_priority;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd3; cmd_pot = 2'd1; cmd_reg = 2'd0; cmd_data = 8'h55;
        step_valid = 1'b1; step_pot = 2'd2; step_up = 1'b1;
        model_cmd(3'd3, 2'd1, 2'd0, 8'h55);
        @(negedge clk);
        cmd_valid = 1'b0; step_valid = 1'b0;
        check_wipers("R10");
        read_dreg("R10", 2'd1, 2'd0);
    endtask

    task automatic t_hold;
        do_cmd(3'd0, 2'd2, 2'd0, 8'h00);
        check8("R11", "read wiper 2", rd_data, mrd);
        do_cmd(3'd2, 2'd2, 2'd0, 8'h11);
        do_cmd(3'd7, 2'd0, 2'd3, 8'h00);
        do_step(2'd2, 1'b0);
        check8("R11", "rd_data held", rd_data, mrd);
        repeat (3) @(negedge clk);
        check_wipers("R11");
        check8("R11", "rd_data idle", rd_data, mrd);
    endtask

    initial begin
        for (int p = 0; p < 4; p++) begin
            mw[p] = 8'h80;
            for (int r = 0; r < 4; r++) md[p][r] = 8'h80;
        end
        mrd = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_direct();
        t_load_one();
        t_save_one();
        t_load_all();
        t_save_all();
        t_step();
        t_saturate();
        t_priority();
        t_hold();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule